// File: doc/BRIEF.md
# Shadow-Latched Real-Time Clock Register Block

This block keeps wall-clock time from a slow 32.768 kHz reference and presents it to a faster register bus. A fractional accumulator turns slow ticks into millisecond steps. The milliseconds counter wraps into a seconds counter. The live counters are not read directly. A snapshot sequencer copies them into bus-side registers once every eight slow ticks. Reading the milliseconds register also captures the snapshot seconds into a shadow register, so a following read of the shadow register returns seconds that match the milliseconds value just read.

The snapshot sequencer is a three-state machine. In RUN it counts slow ticks, and the tick that brings the phase to its last slot moves it to BUSY. In BUSY the busy flag is raised, and the next tick moves it to COPY. COPY lasts one bus cycle: the live counters, already updated by that tick, are copied to the bus side, and the machine returns unconditionally to RUN. Bus writes are accepted only in RUN.

There are two seconds-compare alarms, where a value of zero disables the alarm, and one milliseconds-compare alarm. Together with two countdown events that are driven from outside the block, they set bits in a write-one-to-clear status register. Any status bit whose mask bit is 1 holds the level-high interrupt line.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset, every register reads 0, busy reads 0 and irq_out is 0.
- R2: The counters are copied to the bus side on every eighth slow tick. Seconds (0x008) and milliseconds (0x010) read the values from the latest copy. Busy (0x004, bit 0) reads 1 from the seventh tick of each group of eight until the copy made on the eighth tick.
- R3: A read of 0x010 latches the snapshot seconds into shadow seconds (0x00C). Shadow seconds keeps its value until the next read of 0x010.
- R4: Each slow tick adds ACC_INC to an accumulator. When the sum reaches ACC_MOD, the accumulator subtracts ACC_MOD and milliseconds steps by one. A step taken at MS_WRAP-1 wraps milliseconds to 0 and increments seconds.
- R5: Any bus write made while busy is 1 is ignored, and every register keeps its value.
- R6: An accepted write to 0x008 loads the seconds counter and clears milliseconds and the accumulator. The new value appears on reads only after the next copy.
- R7: Seconds alarms at 0x014 and 0x018 set status bit 0 and status bit 1 on the millisecond wrap that makes seconds equal to the alarm value. An alarm value of 0 never sets its bit.
- R8: The milliseconds alarm at 0x01C sets status bit 2 on every millisecond step whose new value equals the alarm value.
- R9: The status register is at 0x02C. Bit positions are 0 and 1 for the seconds alarms, 2 for the milliseconds alarm, 3 for cdn_force[0] and 4 for cdn_force[1]. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A new event sets its bit even when a clear is written in the same cycle.
- R10: Status bits set whatever the mask (0x028, same bit layout) holds. irq_out is high whenever some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| slow_clk_in | input | 1 | 32.768 kHz reference, asynchronous to clk |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, with unused bits set to 0 |
| cdn_force | input | 2 | One-cycle countdown events that set status bits 3 and 4 |
| irq_out | output | 1 | Level-high interrupt |

## Verification
The bench runs the block with a small accumulator ratio (10 of 25, wrapping at 5 ms), so that the fractional step pattern, the millisecond wraps and the seconds carries all occur within a few dozen ticks. After every tick it reads busy, milliseconds, shadow seconds, seconds and status, which shows whether the copy lands on the eighth tick and whether the shadow tracks the milliseconds read. Writes are made both inside and outside the busy window, which separates gated writes from accepted ones. The status tests use masked and unmasked events, zero and nonzero writes to the clear register, and a disabled alarm, which separates setting a bit from signalling the interrupt.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
    localparam int RTC_ADDR_W = 8;
    localparam int RTC_DATA_W = 32;
    localparam int RTC_EVT_W  = 5;

    localparam logic [RTC_ADDR_W-1:0] ADR_BUSY   = 8'h04;
    localparam logic [RTC_ADDR_W-1:0] ADR_SEC    = 8'h08;
    localparam logic [RTC_ADDR_W-1:0] ADR_SHADOW = 8'h0C;
    localparam logic [RTC_ADDR_W-1:0] ADR_MS     = 8'h10;
    localparam logic [RTC_ADDR_W-1:0] ADR_SAL0   = 8'h14;
    localparam logic [RTC_ADDR_W-1:0] ADR_SAL1   = 8'h18;
    localparam logic [RTC_ADDR_W-1:0] ADR_MSAL   = 8'h1C;
    localparam logic [RTC_ADDR_W-1:0] ADR_MASK   = 8'h28;
    localparam logic [RTC_ADDR_W-1:0] ADR_STAT   = 8'h2C;

    typedef enum logic [1:0] {
        SNAP_RUN  = 2'd0,
        SNAP_BUSY = 2'd1,
        SNAP_COPY = 2'd2
    } snap_state_e;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    output logic tick
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], slow_in};
    end

    // rising edge of the synchronised reference
    assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];

    a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int SEC_W   = 32,
    parameter int MS_WRAP = 1000,
    parameter int ACC_INC = 1000,
    parameter int ACC_MOD = 32768
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        load,
    input  logic [SEC_W-1:0]            load_val,
    input  logic [SEC_W-1:0]            sal0,
    input  logic [SEC_W-1:0]            sal1,
    input  logic [$clog2(MS_WRAP)-1:0]  msal,
    output logic [SEC_W-1:0]            sec_q,
    output logic [$clog2(MS_WRAP)-1:0]  ms_q,
    output logic [2:0]                  hit_q
);
    localparam int MS_W  = $clog2(MS_WRAP);
    localparam int ACC_W = $clog2(ACC_MOD) + 1;
    localparam int SUM_W = ACC_W + 1;
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_WRAP - 1);

    logic [ACC_W-1:0] acc_q, acc_next;
    logic [SUM_W-1:0] acc_sum;
    logic             step, wrap;
    logic [MS_W-1:0]  ms_next;
    logic [SEC_W-1:0] sec_next;

    always_comb begin
        acc_sum  = SUM_W'(acc_q) + SUM_W'(ACC_INC);
        step     = acc_sum >= SUM_W'(ACC_MOD);
        acc_next = step ? ACC_W'(acc_sum - SUM_W'(ACC_MOD)) : ACC_W'(acc_sum);
        wrap     = step && (ms_q == MS_LAST);
        ms_next  = wrap ? '0 : (step ? ms_q + MS_W'(1) : ms_q);
        sec_next = wrap ? sec_q + SEC_W'(1) : sec_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ms_q  <= '0;
            sec_q <= '0;
            hit_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            ms_q  <= '0;
            sec_q <= load_val;
            hit_q <= '0;
        end else if (tick) begin
            acc_q    <= acc_next;
            ms_q     <= ms_next;
            sec_q    <= sec_next;
            hit_q[0] <= wrap && (sec_next == sal0) && (sal0 != '0);
            hit_q[1] <= wrap && (sec_next == sal1) && (sal1 != '0);
            hit_q[2] <= step && (ms_next == msal);
        end else begin
            hit_q <= '0;
        end
    end

    a_r4_ms_range: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST);
    a_r4_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q != $past(sec_q) && !$past(load)) |-> (ms_q == '0 && $past(ms_q) == MS_LAST));
    a_r7_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q[0] |-> $past(sal0) != '0);
endmodule

// File: rtl/rtc_snap_seq.sv
module rtc_snap_seq
    import rtc_shadow_pkg::*;
#(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic busy,
    output logic copy
);
    localparam int PH_W = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_ARM  = PH_W'(PERIOD - 2);

    snap_state_e      state_q, state_d;
    logic [PH_W-1:0]  phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_RUN;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            if (tick) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_RUN:  if (tick && phase_q == PH_ARM) state_d = SNAP_BUSY;
            SNAP_BUSY: if (tick) state_d = SNAP_COPY;
            SNAP_COPY: state_d = SNAP_RUN;
            default:   state_d = SNAP_RUN;
        endcase
    end

    always_comb begin
        busy = (state_q != SNAP_RUN);
        copy = (state_q == SNAP_COPY);
    end

    a_r2_copy_at_phase0: assert property (@(posedge clk) disable iff (!rst_n)
        copy |-> phase_q == '0);
    a_r2_busy_precedes_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy) |-> $past(busy));
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_shadow_pkg::*;
#(
    parameter int SEC_W       = 32,
    parameter int MS_WRAP     = 1000,
    parameter int ACC_INC     = 1000,
    parameter int ACC_MOD     = 32768,
    parameter int SNAP_PERIOD = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk_in,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  cdn_force,
    output logic        irq_out
);
    localparam int MS_W = $clog2(MS_WRAP);

    logic             tick, busy, copy;
    logic [SEC_W-1:0] sec_live, snap_sec, shadow_q, sal0_q, sal1_q;
    logic [MS_W-1:0]  ms_live, snap_ms, msal_q;
    logic [2:0]       hit;
    logic [RTC_EVT_W-1:0] mask_q, stat_q, set_v, clr_v;
    logic             wr_ok, sec_load;
    logic [RTC_DATA_W-1:0] rd_mux, rdata_q;

    rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .slow_in(slow_clk_in), .tick(tick)
    );

    rtc_snap_seq #(.PERIOD(SNAP_PERIOD)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .copy(copy)
    );

    rtc_time_core #(
        .SEC_W(SEC_W), .MS_WRAP(MS_WRAP), .ACC_INC(ACC_INC), .ACC_MOD(ACC_MOD)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(sec_load), .load_val(bus_wdata[SEC_W-1:0]),
        .sal0(sal0_q), .sal1(sal1_q), .msal(msal_q),
        .sec_q(sec_live), .ms_q(ms_live), .hit_q(hit)
    );

    always_comb begin
        wr_ok    = bus_wr && !busy;
        sec_load = wr_ok && (bus_addr == ADR_SEC);
        set_v    = {cdn_force, hit};
        clr_v    = (wr_ok && bus_addr == ADR_STAT) ? bus_wdata[RTC_EVT_W-1:0] : '0;
    end

    // snapshot and shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_sec <= '0;
            snap_ms  <= '0;
            shadow_q <= '0;
        end else begin
            if (copy) begin
                snap_sec <= sec_live;
                snap_ms  <= ms_live;
            end
            if (bus_rd && bus_addr == ADR_MS) shadow_q <= snap_sec;
        end
    end

    // software-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sal0_q <= '0;
            sal1_q <= '0;
            msal_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_v) | set_v;
            if (wr_ok) begin
                unique case (bus_addr)
                    ADR_SAL0: sal0_q <= bus_wdata[SEC_W-1:0];
                    ADR_SAL1: sal1_q <= bus_wdata[SEC_W-1:0];
                    ADR_MSAL: msal_q <= bus_wdata[MS_W-1:0];
                    ADR_MASK: mask_q <= bus_wdata[RTC_EVT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_BUSY:   rd_mux = {{(RTC_DATA_W-1){1'b0}}, busy};
            ADR_SEC:    rd_mux = RTC_DATA_W'(snap_sec);
            ADR_SHADOW: rd_mux = RTC_DATA_W'(shadow_q);
            ADR_MS:     rd_mux = RTC_DATA_W'(snap_ms);
            ADR_SAL0:   rd_mux = RTC_DATA_W'(sal0_q);
            ADR_SAL1:   rd_mux = RTC_DATA_W'(sal1_q);
            ADR_MSAL:   rd_mux = RTC_DATA_W'(msal_q);
            ADR_MASK:   rd_mux = RTC_DATA_W'(mask_q);
            ADR_STAT:   rd_mux = RTC_DATA_W'(stat_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = |(stat_q & mask_q);

    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy) |=> ($stable(mask_q) && $stable(sal0_q) && $stable(sal1_q) && $stable(msal_q)));
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == ADR_STAT && bus_wdata[0] && !hit[0]) |=> !stat_q[0]);
    a_r10_set_without_mask: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> stat_q[0]);
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADR_MS) |=> $stable(shadow_q));
endmodule

// File: tb/rtc_shadow_regs_test.sv
module rtc_shadow_regs_test;
    localparam int T_WRAP = 5;
    localparam int T_INC  = 10;
    localparam int T_MOD  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cdn_force = '0;
    logic        irq_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    int          m_acc = 0, m_phase = 0;
    logic [31:0] m_sec = 0, m_ms = 0, m_snap_sec = 0, m_snap_ms = 0, m_shadow = 0;
    logic [31:0] m_al0 = 0, m_al1 = 0, m_msal = 0, m_mask = 0, m_stat = 0;
    logic        m_busy = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 0;

    rtc_shadow_regs #(.SEC_W(32), .MS_WRAP(T_WRAP), .ACC_INC(T_INC), .ACC_MOD(T_MOD)) uut (
        .clk(clk), .rst_n(rst_n), .slow_clk_in(slow), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cdn_force(cdn_force), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'h04: return {31'b0, m_busy};
            8'h08: return m_snap_sec;
            8'h0C: return m_shadow;
            8'h10: return m_snap_ms;
            8'h14: return m_al0;
            8'h18: return m_al1;
            8'h1C: return m_msal;
            8'h28: return m_mask;
            8'h2C: return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h, want %0h", tag, act, exp);
        end
    endtask

    // driver: issue a read and queue its expected value
    task automatic rd(logic [7:0] a, string tag);
        exp_q.push_back(model_rd(a));
        tag_q.push_back(tag);
        if (a == 8'h10) m_shadow = m_snap_sec;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!m_busy) begin
            case (a)
                8'h08: begin m_sec = d; m_ms = 0; m_acc = 0; end
                8'h14: m_al0 = d;
                8'h18: m_al1 = d;
                8'h1C: m_msal = d & 32'h7;
                8'h28: m_mask = d & 32'h1F;
                8'h2C: m_stat = m_stat & ~(d & 32'h1F);
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic tick_once();
        slow = 1'b1;
        repeat (6) @(negedge clk);
        slow = 1'b0;
        repeat (6) @(negedge clk);
        m_acc += T_INC;
        if (m_acc >= T_MOD) begin
            m_acc -= T_MOD;
            if (m_ms == T_WRAP - 1) begin
                m_ms = 0;
                m_sec++;
                if (m_al0 != 0 && m_sec == m_al0) m_stat |= 32'h1;
                if (m_al1 != 0 && m_sec == m_al1) m_stat |= 32'h2;
            end else m_ms++;
            if (m_ms == m_msal) m_stat |= 32'h4;
        end
        m_phase = (m_phase + 1) % 8;
        if (m_phase == 7) m_busy = 1;
        if (m_phase == 0) begin m_snap_sec = m_sec; m_snap_ms = m_ms; m_busy = 0; end
    endtask

    task automatic wait_idle();
        while (m_busy) tick_once();
    endtask

    task automatic sweep();
        rd(8'h04, "R2 busy");
        rd(8'h10, "R4 milliseconds");
        rd(8'h0C, "R3 shadow");
        rd(8'h08, "R2 seconds");
        rd(8'h2C, "R7 R8 R9 status");
        chk({31'b0, irq_out}, {31'b0, |(m_stat & m_mask)}, "R10 irq");
    endtask

    // monitor: compare read data one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: got %0h, want nothing queued", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        foreach (uut.bus_rdata[i]) ; // no-op keeps loop var local
        rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1"); rd(8'h14, "R1");
        rd(8'h18, "R1"); rd(8'h1C, "R1"); rd(8'h28, "R1"); rd(8'h2C, "R1");
        chk({31'b0, irq_out}, 32'h0, "R1 irq");

        // alarm 0 at 2 s, alarm 1 disabled, ms alarm at 3, mask bit 0
        wr(8'h14, 32'd2); wr(8'h18, 32'd0); wr(8'h1C, 32'd3); wr(8'h28, 32'h1);
        for (int i = 1; i <= 40; i++) begin
            tick_once();
            sweep();
            if (i == 7) begin
                // inside busy window: all writes must be dropped (R5)
                wr(8'h28, 32'h1F); wr(8'h14, 32'd99); wr(8'h08, 32'd77); wr(8'h2C, 32'h1F);
                rd(8'h28, "R5 mask kept"); rd(8'h14, "R5 alarm kept"); rd(8'h2C, "R5 status kept");
            end
        end
        rd(8'h18, "R7 disabled alarm value");

        // write-one-to-clear
        wait_idle();
        wr(8'h2C, 32'h0); rd(8'h2C, "R9 zero write keeps");
        wr(8'h2C, 32'h1); rd(8'h2C, "R9 clear bit0");
        chk({31'b0, irq_out}, {31'b0, |(m_stat & m_mask)}, "R10 irq after clear");

        // countdown events: set without mask, irq only with mask
        wr(8'h28, 32'h0);
        cdn_force = 2'b01; @(negedge clk); cdn_force = 2'b00; m_stat |= 32'h8;
        @(negedge clk);
        rd(8'h2C, "R9 countdown bit3");
        chk({31'b0, irq_out}, 32'h0, "R10 masked event no irq");
        wr(8'h28, 32'h8);
        chk({31'b0, irq_out}, 32'h1, "R10 unmasked event irq");
        cdn_force = 2'b10; @(negedge clk); cdn_force = 2'b00; m_stat |= 32'h10;
        @(negedge clk);
        rd(8'h2C, "R9 countdown bit4");

        // seconds load, visible only after next copy
        wait_idle();
        wr(8'h08, 32'd50);
        rd(8'h08, "R6 old snapshot before copy");
        for (int k = 0; k < 9; k++) begin
            tick_once();
            rd(8'h08, "R6 seconds after load");
            rd(8'h10, "R6 milliseconds after load");
        end

        // milliseconds alarm
        wait_idle();
        wr(8'h1C, 32'd1); wr(8'h2C, 32'h1F);
        rd(8'h2C, "R8 status cleared");
        for (int k = 0; k < 6; k++) begin
            tick_once();
            rd(8'h2C, "R8 ms alarm status");
        end

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule